// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the active-low read and write strobes of a parallel ATA channel for programmed-I/O and multiword DMA transfers. Each request carries a 32-bit timing word in which separate fields give, in controller clock cycles, the address-setup length, the strobe-active length and the strobe-recovery length. There are two sets of these fields: one for task-file register accesses and one for data-port transfers. A request also carries a read/write flag and a task-file/data flag. The block samples the word and the flags on acceptance, then runs its phases and pulses `done` once the recovery ends.

The controller is a four-state machine. IDLE raises `req_ready`. An accepted request moves it to SETUP. When it is chained, it moves straight to STROBE instead. SETUP moves to STROBE once the setup count runs out. STROBE moves to RECOVER once the active count runs out. RECOVER moves back to IDLE at the end of the recovery count and asserts `done` in its last cycle.

A request is chained when it is accepted in the IDLE cycle right after `done` and has the same kind as the previous one. The kind is the pair of the task-file flag and the write flag. A chained request skips SETUP, so the setup time applies only to the first access of a run.

Top module: `ata_strobe_gen`

## Requirements
- R1: A synchronous reset, taken at any time including mid-transfer, returns the block to IDLE. The first clock edge with `rst` high leaves `req_ready`=1, `dior_n`=1, `diow_n`=1 and `done`=0. The next request after reset is never chained.
- R2: `req_ready` is 1 only in IDLE, and a request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the acceptance edge until the block returns to IDLE after `done`.
- R3: `dior_n` goes low only for reads (`req_write`=0) and `diow_n` goes low only for writes (`req_write`=1). Both strobes are never low together, and both are high in IDLE, SETUP and RECOVER.
- R4: For a data access (`req_taskfile`=0), SETUP lasts word[24:22]+1 cycles, the strobe is low for word[8:4]+1 cycles and RECOVER lasts word[3:0]+1 cycles.
- R5: For a task-file access (`req_taskfile`=1), SETUP lasts word[27:25]+1 cycles, the strobe is low for word[17:13]+1 cycles and RECOVER lasts word[12:9]+1 cycles.
- R6: `done` is high for exactly one cycle, the last cycle of RECOVER. The cycle after it is IDLE, with `req_ready`=1.
- R7: The timing word is sampled at acceptance. Changing `req_timing` while a transfer is running does not change that transfer's phase lengths.
- R8: A request accepted in the IDLE cycle right after `done`, with the same write flag and task-file flag as the previous request, skips SETUP. Its strobe goes low in the first cycle after acceptance.
- R9: A request whose write flag or task-file flag differs from the previous one, or one that arrives after at least one extra IDLE cycle, runs the full SETUP phase.
- R10: Bits 31:28 and 21:18 of the timing word have no effect on any phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and accepts a request |
| req_write | input | 1 | 1 = write (strobe `diow_n`), 0 = read (strobe `dior_n`) |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data-port transfer |
| req_timing | input | 32 | Per-device timing word |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle pulse in the last recovery cycle |

## Verification
Data and task-file transfers are run with timing words whose two field sets hold different values. Checking which field set produced each phase length tells the two decodes apart.

Sequences vary the gap between transfers and the kind of each transfer. They separate a chained request, which has no setup cycles, from one where the kind changed or an idle gap intervened, which has the full setup.

Other checks cover:
- a timing word rewritten right after acceptance;
- words with junk in the ignored bits;
- words with every field at its minimum or at its maximum;
- a reset in the middle of a setup phase, which must also break chaining.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 5;

    // data-port field positions
    localparam int D_REC_LSB = 0;
    localparam int D_REC_W   = 4;
    localparam int D_ACT_LSB = 4;
    localparam int D_ACT_W   = 5;
    localparam int D_PRE_LSB = 22;
    localparam int D_PRE_W   = 3;

    // task-file field positions
    localparam int C_REC_LSB = 9;
    localparam int C_REC_W   = 4;
    localparam int C_ACT_LSB = 13;
    localparam int C_ACT_W   = 5;
    localparam int C_PRE_LSB = 25;
    localparam int C_PRE_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } strobe_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] pre;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] rec;
    } phase_len_t;

endpackage

// File: rtl/ata_strobe_field_sel.sv
module ata_strobe_field_sel
    import ata_strobe_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              taskfile,
    output phase_len_t        len
);

    phase_len_t data_len;
    phase_len_t cmd_len;

    // bits outside all timing fields are deliberately dropped
    logic unused_bits;
    assign unused_bits = ^{word[31:28], word[21:18]};

    always_comb begin
        data_len.pre = CNT_W'(word[D_PRE_LSB +: D_PRE_W]);
        data_len.act = CNT_W'(word[D_ACT_LSB +: D_ACT_W]);
        data_len.rec = CNT_W'(word[D_REC_LSB +: D_REC_W]);
        cmd_len.pre  = CNT_W'(word[C_PRE_LSB +: C_PRE_W]);
        cmd_len.act  = CNT_W'(word[C_ACT_LSB +: C_ACT_W]);
        cmd_len.rec  = CNT_W'(word[C_REC_LSB +: C_REC_W]);
        len          = taskfile ? cmd_len : data_len;
    end

endmodule

// File: rtl/ata_strobe_phase_cnt.sv
module ata_strobe_phase_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // a loaded value v keeps the phase running for v+1 cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strobe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_taskfile,
    input  logic [WORD_W-1:0] req_timing,
    output logic              dior_n,
    output logic              diow_n,
    output logic              done
);

    strobe_state_t     state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              wr_q;
    logic              tf_q;
    logic [1:0]        kind_q;
    logic              chain_q;

    logic              accept;
    logic              skip_setup;
    logic              cnt_zero;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic [WORD_W-1:0] sel_word;
    logic              sel_tf;
    phase_len_t        len;

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign skip_setup = chain_q && ({req_taskfile, req_write} == kind_q);

    // while idle the incoming word is decoded, afterwards the sampled one
    assign sel_word = (state_q == ST_IDLE) ? req_timing   : word_q;
    assign sel_tf   = (state_q == ST_IDLE) ? req_taskfile : tf_q;

    ata_strobe_field_sel u_sel (
        .word     (sel_word),
        .taskfile (sel_tf),
        .len      (len)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)   state_d = skip_setup ? ST_STROBE : ST_SETUP;
            ST_SETUP:   if (cnt_zero) state_d = ST_STROBE;
            ST_STROBE:  if (cnt_zero) state_d = ST_RECOVER;
            ST_RECOVER: if (cnt_zero) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // phase counter reload on every state change
    always_comb begin
        cnt_load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP:   cnt_val = len.pre;
            ST_STROBE:  cnt_val = len.act;
            ST_RECOVER: cnt_val = len.rec;
            default:    cnt_val = '0;
        endcase
    end

    ata_strobe_phase_cnt #(
        .W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    // state register and request sampling
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            wr_q    <= 1'b0;
            tf_q    <= 1'b0;
            kind_q  <= 2'b00;
            chain_q <= 1'b0;
        end else begin
            state_q <= state_d;
            chain_q <= done;
            if (accept) begin
                word_q <= req_timing;
                wr_q   <= req_write;
                tf_q   <= req_taskfile;
                kind_q <= {req_taskfile, req_write};
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        dior_n    = 1'b1;
        diow_n    = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_SETUP:   ;
            ST_STROBE:  begin
                dior_n = wr_q;
                diow_n = !wr_q;
            end
            ST_RECOVER: done = cnt_zero;
            default:    ;
        endcase
    end

endmodule

// File: rtl/ata_strobe_chk.sv
module ata_strobe_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic dior_n,
    input logic diow_n,
    input logic done
);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            assert_reset_idle_R1: assert (req_ready && dior_n && diow_n && !done)
                else $error("outputs not idle after reset");
        end
    end

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (dior_n || diow_n));

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (dior_n && diow_n && !done));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    assert_done_strobes_high_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (dior_n && diow_n));

endmodule

bind ata_strobe_gen ata_strobe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .done      (done)
);

// File: tb/tb_ata_strobe_gen.sv
`timescale 1ns/1ps
module tb_ata_strobe_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic        req_taskfile;
    logic [31:0] req_timing;
    logic        dior_n;
    logic        diow_n;
    logic        done;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    ata_strobe_gen dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_write    (req_write),
        .req_taskfile (req_taskfile),
        .req_timing   (req_timing),
        .dior_n       (dior_n),
        .diow_n       (diow_n),
        .done         (done)
    );

    // {gap, write, taskfile, word}
    localparam int NV = 9;
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 32'h0040_0032},
        {1'b0, 1'b0, 1'b0, 32'h0541_2E00},
        {1'b0, 1'b1, 1'b0, 32'h0541_2E00},
        {1'b0, 1'b1, 1'b1, 32'h0DC0_87FF},
        {1'b0, 1'b1, 1'b1, 32'h0000_0200},
        {1'b1, 1'b1, 1'b1, 32'h0000_0200},
        {1'b0, 1'b0, 1'b1, 32'hF23C_4A00},
        {1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF},
        {1'b0, 1'b1, 1'b0, 32'h0000_0000}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic xfer(input logic wr, input logic tf, input logic [31:0] word,
                        input logic use_alt, input logic [31:0] alt,
                        output int s, output int a, output int r);
        int  guard;
        bit  phase;
        bit  other_bad;
        bit  ready_bad;
        @(negedge clk);
        chk("R2 ready in idle", int'(req_ready), 1);
        chk("R6 done low in idle", int'(done), 0);
        req_valid    = 1'b1;
        req_write    = wr;
        req_taskfile = tf;
        req_timing   = word;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (use_alt) req_timing = alt;
        s = 0; a = 0; r = 0; guard = 0; phase = 1'b0;
        other_bad = 1'b0; ready_bad = 1'b0;
        forever begin
            if ((wr ? dior_n : diow_n) != 1'b1) other_bad = 1'b1;
            if (req_ready) ready_bad = 1'b1;
            if (!(wr ? diow_n : dior_n)) begin
                a++;
                phase = 1'b1;
            end else if (!phase) s++;
            else r++;
            if (done) break;
            guard++;
            if (guard > 200) begin
                chk("R6 done never seen", 0, 1);
                break;
            end
            @(negedge clk);
        end
        chk("R3 other strobe stayed high", int'(other_bad), 0);
        chk("R2 ready low while busy", int'(ready_bad), 0);
    endtask

    function automatic int f_pre(input logic tf, input logic [31:0] w);
        return tf ? int'(w[27:25]) + 1 : int'(w[24:22]) + 1;
    endfunction
    function automatic int f_act(input logic tf, input logic [31:0] w);
        return tf ? int'(w[17:13]) + 1 : int'(w[8:4]) + 1;
    endfunction
    function automatic int f_rec(input logic tf, input logic [31:0] w);
        return tf ? int'(w[12:9]) + 1 : int'(w[3:0]) + 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int s, a, r;
        logic [1:0] prev_kind;
        bit have_prev;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_taskfile = 1'b0; req_timing = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 dior_n after reset", int'(dior_n), 1);
        chk("R1 diow_n after reset", int'(diow_n), 1);
        chk("R1 done after reset", int'(done), 0);
        rst = 1'b0;

        have_prev = 1'b0;
        prev_kind = 2'b00;
        for (int i = 0; i < NV; i++) begin
            logic gap, wr, tf;
            logic [31:0] w;
            int exp_s;
            {gap, wr, tf, w} = VEC[i];
            if (gap) idle_cycle();
            xfer(wr, tf, w, 1'b0, 32'h0, s, a, r);
            // R8 chained same kind skips setup, R9 otherwise full setup
            exp_s = (!gap && have_prev && prev_kind == {tf, wr}) ? 0 : f_pre(tf, w);
            chk(tf ? "R5 R8 R9 R10 setup" : "R4 R8 R9 R10 setup", s, exp_s);
            chk(tf ? "R5 R10 active" : "R4 R10 active", a, f_act(tf, w));
            chk(tf ? "R5 R10 recovery" : "R4 R10 recovery", r, f_rec(tf, w));
            prev_kind = {tf, wr};
            have_prev = 1'b1;
        end

        // R7: word rewritten right after acceptance
        idle_cycle();
        xfer(1'b0, 1'b0, 32'h0040_0032, 1'b1, 32'hFFFF_FFFF, s, a, r);
        chk("R7 setup uses sampled word", s, 2);
        chk("R7 active uses sampled word", a, 4);
        chk("R7 recovery uses sampled word", r, 3);

        // R1: reset in the middle of a setup phase, then no chaining
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_taskfile = 1'b0;
        req_timing = 32'h01C0_0011;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 mid-transfer reset ready", int'(req_ready), 1);
        chk("R1 mid-transfer reset dior_n", int'(dior_n), 1);
        chk("R1 mid-transfer reset done", int'(done), 0);
        rst = 1'b0;
        xfer(1'b0, 1'b0, 32'h01C0_0011, 1'b0, 32'h0, s, a, r);
        chk("R1 R9 setup after reset", s, 8);
        chk("R4 active after reset", a, 2);
        chk("R4 recovery after reset", r, 2);
        // immediately chained follow-up of the same kind
        xfer(1'b0, 1'b0, 32'h01C0_0011, 1'b0, 32'h0, s, a, r);
        chk("R8 chained setup skipped", s, 0);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule